// File: doc/BRIEF.md
# Dual-Scan Passive Panel Timing Generator

This block drives the digital side of a 640x480 colour passive-matrix LCD module that is split into two 640x240 halves and refreshed as two panels at once. While row `r` of the upper half is shifted into the column drivers on one 8-bit bus, row `r + 240` of the lower half is shifted on a second 8-bit bus during the same clocks. Each pixel is three on/off subpixels (red, green, blue), so each bus word carries eight subpixel bits. A word therefore does not line up with pixel boundaries. The block packs the pixels it fetches into such words.

Pixels come from a source, such as a frame buffer or a test pattern. The block issues one request per cycle on a simple fetch port that gives the column and both row numbers. The source answers combinationally in the same cycle with one 3-bit pixel for each half. The block produces the panel's shift clock, the line latch pulse after each row and a frame marker that accompanies the first row. It also provides a frame counter that a later gray-level dithering stage can use. A rate select input doubles the refresh rate, for example from 120 Hz to 240 Hz at the same system clock. The block applies a new rate only at a frame boundary.

The flow through the sequencer follows four named states:
- IDLE is held in reset, and the block leaves it on the first clock after reset (transition *start*).
- PRIME fetches the first word of a row (transition *primed*, to SHIFT).
- SHIFT outputs the words of the row (transition *row shifted*, to LATCH, after the last word).
- LATCH raises the line pulse (transition *latched*, back to PRIME). At the last row this transition also begins the next frame.

Top module: `dscan_lcd_timing`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `shift_clk`, `line_pulse`, `frame_mark`, `fetch_en`, `dat_up`, `dat_lo` and `frame_cnt` are all zero. The first row begins on the next clock.
- R2: The lower bus carries row `fetch_row + V_HALF` during the same word periods in which the upper bus carries upper row `fetch_row`. `fetch_row_lo` always equals `fetch_row + V_HALF`.
- R3: Subpixel bits are packed with the most significant bit first, in the order red, green, blue, repeating. `pix_*[2]` is red, `[1]` is green and `[0]` is blue. Bit 7 of word k of a row holds subpixel 8k, and bit 0 holds subpixel 8k+7. A row has `H_PIX*3/8` words.
- R4: Within each row, the fetch requests (`fetch_en` high) give the columns 0, 1, ..., `H_PIX-1` in ascending order, with one column per request. `fetch_col` is always below `H_PIX`.
- R5: Each data word is held for one word period of W cycles. `shift_clk` is low for the first W/2 cycles of the period and high for the last W/2 cycles. The data does not change while `shift_clk` is high, and `shift_clk` is low outside word periods.
- R6: After the last word of a row, `line_pulse` is high for L cycles while `shift_clk` is low. A 4-cycle gap with both signals low then precedes the first word of the next row. No fetch takes place during the line pulse.
- R7: `frame_mark` rises at the start of the 4-cycle gap that comes before row 0. It stays high through the line pulse of row 0 and falls when row 1 starts.
- R8: With `rate_sel` = 1, W = `WORD_CLKS` and L = `LINE_CLKS`. With `rate_sel` = 0, W and L are twice those values, which halves the frame rate. `rate_sel` is sampled only at the start of a frame, so a change during a frame has no effect until the next frame.
- R9: `frame_cnt` increases by one, wrapping at 2^`FCNT_W`, in the same cycle in which `frame_mark` rises, and it is otherwise constant. It reads 1 during the first frame after reset.
- R10: The rows run from 0 to `V_HALF-1`. After the line pulse of the last row, row 0 of a new frame follows directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_sel | input | 1 | 1 selects the double refresh rate; sampled at each frame start |
| fetch_en | output | 1 | Pixel request valid in this cycle |
| fetch_col | output | $clog2(H_PIX) | Column of the requested pixel |
| fetch_row | output | $clog2(2*V_HALF) | Upper-half row being fetched |
| fetch_row_lo | output | $clog2(2*V_HALF) | Matching lower-half row (fetch_row + V_HALF) |
| pix_up | input | 3 | Upper-half pixel {R,G,B}, valid in the request cycle |
| pix_lo | input | 3 | Lower-half pixel {R,G,B}, valid in the request cycle |
| shift_clk | output | 1 | Column shift clock |
| line_pulse | output | 1 | Row latch pulse |
| frame_mark | output | 1 | First-row frame marker |
| dat_up | output | BUS_W | Packed subpixel word for the upper half |
| dat_lo | output | BUS_W | Packed subpixel word for the lower half |
| frame_cnt | output | FCNT_W | Frame counter for dithering |

## Verification
The hardest situation to reach from the ports is a change of `rate_sel` in the middle of a frame. The change must not alter the current frame and must take effect exactly at the next frame marker, and the frame counter must wrap at the same time. The stimulus reaches this state by changing `rate_sel` at the moment the frame marker falls in each frame. It follows a plan of rates, so every frame boundary sees a new value that was present for most of the previous frame. A small panel geometry and a narrow frame counter let several frames and a counter wrap happen within a short run. The pixel pattern varies with both row and column, so the packing is checked across pixel boundaries on both buses.

// File: rtl/dscan_pkg.sv
package dscan_pkg;

    // Subpixel bits carried by one pixel (R, G, B).
    localparam int PIX_BITS = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRIME,
        ST_SHIFT,
        ST_LATCH
    } scan_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dscan_packer.sv
// Accumulates 3-bit pixels MSB-first and hands out BUS_W-bit words.
module dscan_packer
    import dscan_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int FILL_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  logic                pop,
    input  logic [FILL_W-1:0]   fill,
    input  logic [PIX_BITS-1:0] pix,
    output logic [BUS_W-1:0]    word
);

    // A push only occurs while fill < BUS_W, so BUS_W-1+PIX_BITS bits suffice.
    localparam int ACC_W = BUS_W + PIX_BITS - 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] ins;

    always_comb begin
        ins = ACC_W'(pix) << (ACC_W - PIX_BITS - int'(fill));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            word <= '0;
        end else if (pop) begin
            word <= acc[ACC_W-1 -: BUS_W];
            acc  <= acc << BUS_W;
        end else if (push) begin
            acc  <= acc | ins;
        end
    end

endmodule

// File: rtl/dscan_seq.sv
// Row/frame sequencer: state machine, counters and panel strobes.
module dscan_seq
    import dscan_pkg::*;
#(
    parameter int H_PIX     = 640,
    parameter int V_HALF    = 240,
    parameter int BUS_W     = 8,
    parameter int WORD_CLKS = 4,
    parameter int LINE_CLKS = 8,
    parameter int FCNT_W    = 8,
    localparam int COL_W    = $clog2(H_PIX),
    localparam int ROW_W    = $clog2(2 * V_HALF),
    localparam int FILL_W   = $clog2(BUS_W + PIX_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_sel,
    output logic              push,
    output logic              pop,
    output logic [FILL_W-1:0] fill,
    output logic [COL_W-1:0]  col,
    output logic [ROW_W-1:0]  row,
    output logic              shift_clk,
    output logic              line_pulse,
    output logic              frame_mark,
    output logic [FCNT_W-1:0] frame_cnt
);

    localparam int NWORDS      = H_PIX * PIX_BITS / BUS_W;
    localparam int FETCH_SLOTS = ceil_div(BUS_W, PIX_BITS);
    localparam int PRIME_CLKS  = FETCH_SLOTS + 1;
    localparam int MAX_SPAN    = max3(2 * WORD_CLKS, 2 * LINE_CLKS, PRIME_CLKS);
    localparam int TICK_W      = $clog2(MAX_SPAN + 1);
    localparam int WORD_W      = (NWORDS > 1) ? $clog2(NWORDS) : 1;

    scan_state_e       state, state_d;
    logic [TICK_W-1:0] tick;
    logic [TICK_W-1:0] word_len, half_len, line_len;
    logic [WORD_W-1:0] word;
    logic              col_full;
    logic              fast_q;
    logic              prime_end, word_end, line_end;
    logic              last_word, last_row, frame_start;

    // Period lengths for the rate latched at the current frame start.
    always_comb begin
        word_len = fast_q ? TICK_W'(WORD_CLKS)     : TICK_W'(2 * WORD_CLKS);
        half_len = fast_q ? TICK_W'(WORD_CLKS / 2) : TICK_W'(WORD_CLKS);
        line_len = fast_q ? TICK_W'(LINE_CLKS)     : TICK_W'(2 * LINE_CLKS);
    end

    always_comb begin
        prime_end   = (state == ST_PRIME) && (tick == TICK_W'(PRIME_CLKS - 1));
        word_end    = (state == ST_SHIFT) && (tick == word_len - 1'b1);
        line_end    = (state == ST_LATCH) && (tick == line_len - 1'b1);
        last_word   = (word == WORD_W'(NWORDS - 1));
        last_row    = (row == ROW_W'(V_HALF - 1));
        frame_start = (state == ST_IDLE) || (line_end && last_row);
    end

    // Transitions: start, primed, row shifted, latched.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  state_d = ST_PRIME;
            ST_PRIME: state_d = prime_end ? ST_SHIFT : ST_PRIME;
            ST_SHIFT: state_d = (word_end && last_word) ? ST_LATCH : ST_SHIFT;
            ST_LATCH: state_d = line_end ? ST_PRIME : ST_LATCH;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Fetch and word hand-off strobes.
    always_comb begin
        push = ((state == ST_PRIME) || (state == ST_SHIFT))
             && (tick < TICK_W'(FETCH_SLOTS))
             && (fill < FILL_W'(BUS_W))
             && !col_full;
        pop  = prime_end || (word_end && !last_word);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Counters.
    always_ff @(posedge clk) begin
        if (rst) begin
            tick      <= '0;
            word      <= '0;
            row       <= '0;
            col       <= '0;
            col_full  <= 1'b0;
            fill      <= '0;
            fast_q    <= 1'b0;
            frame_cnt <= '0;
        end else begin
            if ((state_d != state) || word_end) begin
                tick <= '0;
            end else begin
                tick <= tick + 1'b1;
            end

            unique case ({push, pop})
                2'b10:   fill <= fill + FILL_W'(PIX_BITS);
                2'b01:   fill <= fill - FILL_W'(BUS_W);
                default: fill <= fill;
            endcase

            if ((state_d == ST_PRIME) && (state != ST_PRIME)) begin
                col      <= '0;
                col_full <= 1'b0;
            end else if (push) begin
                if (col == COL_W'(H_PIX - 1)) begin
                    col_full <= 1'b1;
                end else begin
                    col <= col + 1'b1;
                end
            end

            if (word_end) begin
                word <= last_word ? '0 : word + 1'b1;
            end

            if (frame_start) begin
                row       <= '0;
                fast_q    <= rate_sel;
                frame_cnt <= frame_cnt + 1'b1;
            end else if (line_end) begin
                row <= row + 1'b1;
            end
        end
    end

    // Panel strobes.
    always_comb begin
        shift_clk  = 1'b0;
        line_pulse = 1'b0;
        frame_mark = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_PRIME: begin
                frame_mark = (row == '0);
            end
            ST_SHIFT: begin
                shift_clk  = (tick >= half_len);
                frame_mark = (row == '0);
            end
            ST_LATCH: begin
                line_pulse = 1'b1;
                frame_mark = (row == '0);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/dscan_lcd_timing.sv
module dscan_lcd_timing
    import dscan_pkg::*;
#(
    parameter int H_PIX     = 640,
    parameter int V_HALF    = 240,
    parameter int BUS_W     = 8,
    parameter int WORD_CLKS = 4,
    parameter int LINE_CLKS = 8,
    parameter int FCNT_W    = 8,
    localparam int COL_W    = $clog2(H_PIX),
    localparam int ROW_W    = $clog2(2 * V_HALF)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rate_sel,
    output logic                fetch_en,
    output logic [COL_W-1:0]    fetch_col,
    output logic [ROW_W-1:0]    fetch_row,
    output logic [ROW_W-1:0]    fetch_row_lo,
    input  logic [PIX_BITS-1:0] pix_up,
    input  logic [PIX_BITS-1:0] pix_lo,
    output logic                shift_clk,
    output logic                line_pulse,
    output logic                frame_mark,
    output logic [BUS_W-1:0]    dat_up,
    output logic [BUS_W-1:0]    dat_lo,
    output logic [FCNT_W-1:0]   frame_cnt
);

    localparam int FILL_W = $clog2(BUS_W + PIX_BITS);
    localparam int HALVES = 2;

    logic              push, pop;
    logic [FILL_W-1:0] fill;
    logic [ROW_W-1:0]  row;
    logic [PIX_BITS-1:0] half_pix  [HALVES];
    logic [BUS_W-1:0]    half_word [HALVES];

    dscan_seq #(
        .H_PIX     (H_PIX),
        .V_HALF    (V_HALF),
        .BUS_W     (BUS_W),
        .WORD_CLKS (WORD_CLKS),
        .LINE_CLKS (LINE_CLKS),
        .FCNT_W    (FCNT_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .rate_sel   (rate_sel),
        .push       (push),
        .pop        (pop),
        .fill       (fill),
        .col        (fetch_col),
        .row        (row),
        .shift_clk  (shift_clk),
        .line_pulse (line_pulse),
        .frame_mark (frame_mark),
        .frame_cnt  (frame_cnt)
    );

    assign half_pix[0] = pix_up;
    assign half_pix[1] = pix_lo;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        dscan_packer #(
            .BUS_W  (BUS_W),
            .FILL_W (FILL_W)
        ) u_pack (
            .clk  (clk),
            .rst  (rst),
            .push (push),
            .pop  (pop),
            .fill (fill),
            .pix  (half_pix[h]),
            .word (half_word[h])
        );
    end

    assign dat_up       = half_word[0];
    assign dat_lo       = half_word[1];
    assign fetch_en     = push;
    assign fetch_row    = row;
    assign fetch_row_lo = row + ROW_W'(V_HALF);

endmodule

// File: rtl/dscan_lcd_timing_chk.sv
module dscan_lcd_timing_chk #(
    parameter int H_PIX  = 640,
    parameter int BUS_W  = 8,
    parameter int FCNT_W = 8,
    localparam int COL_W = $clog2(H_PIX)
) (
    input logic              clk,
    input logic              rst,
    input logic              fetch_en,
    input logic [COL_W-1:0]  fetch_col,
    input logic              shift_clk,
    input logic              line_pulse,
    input logic              frame_mark,
    input logic [BUS_W-1:0]  dat_up,
    input logic [BUS_W-1:0]  dat_lo,
    input logic [FCNT_W-1:0] frame_cnt
);

    AST_DATA_HELD_CL2: assert property (@(posedge clk) disable iff (rst)
        (shift_clk && $past(shift_clk)) |-> ($stable(dat_up) && $stable(dat_lo))); // R5

    AST_CL2_QUIET_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        line_pulse |-> !shift_clk); // R6

    AST_LINE_AFTER_SHIFT: assert property (@(posedge clk) disable iff (rst)
        $rose(line_pulse) |-> $past(shift_clk)); // R6

    AST_NO_FETCH_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        line_pulse |-> !fetch_en); // R6

    AST_FLM_ENDS_AFTER_LINE: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_mark) |-> $past(line_pulse)); // R7

    AST_FETCH_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
        fetch_en |-> (int'(fetch_col) < H_PIX)); // R4

    AST_FCNT_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_mark) |-> (frame_cnt == FCNT_W'($past(frame_cnt) + 1'b1))); // R9

    AST_FCNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$rose(frame_mark) |-> $stable(frame_cnt)); // R9

endmodule

bind dscan_lcd_timing dscan_lcd_timing_chk #(
    .H_PIX  (H_PIX),
    .BUS_W  (BUS_W),
    .FCNT_W (FCNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fetch_en   (fetch_en),
    .fetch_col  (fetch_col),
    .shift_clk  (shift_clk),
    .line_pulse (line_pulse),
    .frame_mark (frame_mark),
    .dat_up     (dat_up),
    .dat_lo     (dat_lo),
    .frame_cnt  (frame_cnt)
);

// File: tb/dscan_lcd_timing_tb.sv
module dscan_lcd_timing_tb;

    localparam int H    = 16;
    localparam int V    = 3;
    localparam int BW   = 8;
    localparam int WC   = 4;
    localparam int LC   = 3;
    localparam int FW   = 2;
    localparam int NW   = H * 3 / BW;
    localparam int COLW = $clog2(H);
    localparam int ROWW = $clog2(2 * V);
    localparam int NFR  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_sel = 1'b0;
    logic fetch_en, shift_clk, line_pulse, frame_mark;
    logic [COLW-1:0] fetch_col;
    logic [ROWW-1:0] fetch_row, fetch_row_lo;
    logic [2:0] pix_up, pix_lo;
    logic [BW-1:0] dat_up, dat_lo;
    logic [FW-1:0] frame_cnt;

    always #5 clk = ~clk;

    dscan_lcd_timing #(
        .H_PIX(H), .V_HALF(V), .BUS_W(BW),
        .WORD_CLKS(WC), .LINE_CLKS(LC), .FCNT_W(FW)
    ) u_dut (
        .clk(clk), .rst(rst), .rate_sel(rate_sel),
        .fetch_en(fetch_en), .fetch_col(fetch_col),
        .fetch_row(fetch_row), .fetch_row_lo(fetch_row_lo),
        .pix_up(pix_up), .pix_lo(pix_lo),
        .shift_clk(shift_clk), .line_pulse(line_pulse), .frame_mark(frame_mark),
        .dat_up(dat_up), .dat_lo(dat_lo), .frame_cnt(frame_cnt)
    );

    // Test image: panel row 0..2V-1, column 0..H-1.
    function automatic logic [2:0] pixf(input int prow, input int pcol);
        return 3'((prow * 5 + pcol * 3 + prow / 2) % 8);
    endfunction

    assign pix_up = pixf(int'(fetch_row), int'(fetch_col));
    assign pix_lo = pixf(int'(fetch_row_lo), int'(fetch_col));

    // R3: bit 7-j of word k holds subpixel 8k+j; subpixel s is colour s%3 of pixel s/3.
    function automatic logic [BW-1:0] exp_word(input int prow, input int k);
        logic [BW-1:0] w;
        logic [2:0] p;
        for (int j = 0; j < BW; j++) begin
            p = pixf(prow, (k * BW + j) / 3);
            w[BW-1-j] = p[2 - ((k * BW + j) % 3)];
        end
        return w;
    endfunction

    typedef struct packed {
        logic          cl1;
        logic          cl2;
        logic          flm;
        logic [BW-1:0] du;
        logic [BW-1:0] dl;
        logic [FW-1:0] fc;
    } exp_t;

    exp_t q[$];
    int   plan[NFR] = '{0, 1, 1, 0, 1};
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    int   fidx  = 0;
    int   colexp = 0;
    logic prev_flm = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Behavioural per-cycle expectation for the whole run (R5 R6 R7 R8 R9 R10).
    task automatic build();
        exp_t e;
        logic [BW-1:0] lu, ll;
        int w, l;
        lu = '0;
        ll = '0;
        e = '0;
        q.push_back(e);                         // cycle before the first row
        for (int f = 0; f < NFR; f++) begin
            w = plan[f] ? WC : 2 * WC;
            l = plan[f] ? LC : 2 * LC;
            for (int r = 0; r < V; r++) begin
                for (int t = 0; t < 4; t++) begin
                    e = '{cl1: 1'b0, cl2: 1'b0, flm: (r == 0), du: lu, dl: ll, fc: FW'(f + 1)};
                    q.push_back(e);
                end
                for (int k = 0; k < NW; k++) begin
                    lu = exp_word(r, k);
                    ll = exp_word(r + V, k);
                    for (int t = 0; t < w; t++) begin
                        e = '{cl1: 1'b0, cl2: (t >= w / 2), flm: (r == 0), du: lu, dl: ll, fc: FW'(f + 1)};
                        q.push_back(e);
                    end
                end
                for (int t = 0; t < l; t++) begin
                    e = '{cl1: 1'b1, cl2: 1'b0, flm: (r == 0), du: lu, dl: ll, fc: FW'(f + 1)};
                    q.push_back(e);
                end
            end
        end
    endtask

    task automatic compare(input exp_t e);
        chk("R5 R8 shift_clk", int'(shift_clk), int'(e.cl2));
        chk("R6 line_pulse", int'(line_pulse), int'(e.cl1));
        chk("R7 R10 frame_mark", int'(frame_mark), int'(e.flm));
        chk("R3 dat_up", int'(dat_up), int'(e.du));
        chk("R2 dat_lo", int'(dat_lo), int'(e.dl));
        chk("R9 frame_cnt", int'(frame_cnt), int'(e.fc));
        if (line_pulse) colexp = 0;
        if (fetch_en) begin
            chk("R4 fetch_col", int'(fetch_col), colexp);
            chk("R2 fetch_row_lo", int'(fetch_row_lo), int'(fetch_row) + V);
            colexp++;
        end
        // R8: change the rate mid-frame, right after the marker falls.
        if (prev_flm && !frame_mark) begin
            fidx++;
            if (fidx < NFR) rate_sel = plan[fidx][0];
        end
        prev_flm = frame_mark;
    endtask

    initial begin
        rate_sel = plan[0][0];
        build();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs idle while in reset.
        chk("R1 reset shift_clk", int'(shift_clk), 0);
        chk("R1 reset line_pulse", int'(line_pulse), 0);
        chk("R1 reset frame_mark", int'(frame_mark), 0);
        chk("R1 reset fetch_en", int'(fetch_en), 0);
        chk("R1 reset data", int'(dat_up) + int'(dat_lo), 0);
        chk("R1 reset frame_cnt", int'(frame_cnt), 0);
        rst = 1'b0;
        #1;
        compare(q.pop_front());
        while (q.size() > 0) begin
            @(negedge clk);
            compare(q.pop_front());
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog expired actual=%0d expected=0 entries left", q.size());
            finish_run();
        end
    end

endmodule